// File: doc/BRIEF.md
# Multi-Queue Read Port with Switch Latency

This block is the read side of a buffer that keeps four independent queues behind one shared output bus. A simple per-queue push port fills the queues. On every rising edge the read side takes a five-bit read address, an address-enable, a read enable and a flag strobe. The upper address bits are a device field that is compared against a local identifier. The lower bits name the queue. The output bus always carries words from the currently selected queue, in first-word-fall-through order. When the selected queue changes, the bus follows a fixed two-edge sequence: first one last word from the queue being left, then the head of the newly chosen queue.

All queue words sit in one shared memory, addressed by queue number and slot. The output data register is also the memory's read register. The same address bus is used for a second purpose: when the flag strobe is high, its device field is latched as the device selection for an external flag bus. In that case the queue bits have no effect.

Top module: `mqr_read_port`

## Requirements
- R1: Synchronous active-high reset leaves dout_valid at 0, rd_qsel at 0, dout at 0, flag_dev at 0, every q_empty bit at 1 and every q_full bit at 0.
- R2: Each queue stores up to 16 words of 18 bits. q_full[n] is high when queue n holds 16 words. A push into a full queue is dropped and is never read out.
- R3: Fall-through: if dout_valid is 0 and the selected queue is non-empty before an edge, that edge loads the queue's oldest word onto dout and sets dout_valid, without rd_en. A word pushed on edge k therefore appears on dout at edge k+1 at the earliest.
- R4: While dout_valid is 1, an edge with rd_en high replaces dout with the next word of the selected queue. If that queue is empty, the edge clears dout_valid and leaves dout unchanged. An edge with rd_en low and no queue switch in progress leaves dout and dout_valid unchanged.
- R5: A new queue is selected on an edge only when rd_addr_en is high and rd_addr[4:2] equals the DEV_ID parameter. rd_qsel then takes rd_addr[1:0]. Any other edge leaves rd_qsel unchanged.
- R6: On the first edge after a selecting edge, one word from the previously selected queue is loaded onto dout, whatever rd_en is. On the second edge, the oldest word of the newly selected queue is loaded, whatever rd_en is.
- R7: Selection does not depend on rd_en. On the selecting edge itself, the normal R3/R4 read still acts on the previously selected queue.
- R8: A forced or normal read from an empty queue does not move that queue's pointer, leaves dout unchanged and drives dout_valid to 0.
- R9: An edge with flag_strobe high loads flag_dev with rd_addr[4:2] and sets flag_hit to 1 exactly when that field equals DEV_ID. rd_addr[1:0] and rd_addr_en have no effect on this. With flag_strobe low, flag_dev and flag_hit hold.
- R10: Pushes into a queue other than the selected one do not change dout or dout_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push one word |
| wr_q | input | 2 | Queue that receives the push |
| wr_data | input | 18 | Word to push |
| rd_addr | input | 5 | [4:2] device field, [1:0] queue field |
| rd_addr_en | input | 1 | Take a queue select from rd_addr |
| rd_en | input | 1 | Consume the word on dout |
| flag_strobe | input | 1 | Latch the flag-bus device field |
| dout | output | 18 | Shared output bus |
| dout_valid | output | 1 | dout holds a word not yet consumed |
| rd_qsel | output | 2 | Currently selected read queue |
| q_empty | output | 4 | Per-queue empty |
| q_full | output | 4 | Per-queue full |
| flag_dev | output | 3 | Latched device selection for the flag bus |
| flag_hit | output | 1 | Latched selection matches this device |

## Verification
The main function is tried with three kinds of traffic. The first is pushes into the selected queue while it is idle, which isolates the one-edge fall-through latency. The second is read-enable runs over a full queue, which distinguish in-order delivery from a dropped seventeenth word. The third is queue switches with rd_en both high and low, which separate the read on the selecting edge, the forced word from the old queue and the head of the new queue. A switch away from a queue that has just been emptied shows that an empty forced read holds the bus and only clears valid. Full sweeps over all 32 address values, once with the strobe and once with the address-enable, separate the device compare from the ignored queue bits.

// File: rtl/mqr_pkg.sv
package mqr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OLD  = 2'd1,
    PH_NEW  = 2'd2
  } phase_t;
endpackage

// File: rtl/mqr_ptrs.sv
module mqr_ptrs #(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ-1:0]    push,
  input  logic [NQ-1:0]    pop,
  output logic [NQ-1:0]    empty,
  output logic [NQ-1:0]    full,
  output logic [NQ*AW-1:0] wptr_flat,
  output logic [NQ*AW-1:0] rptr_flat
);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push[g]) wp <= wp + 1'b1;
        if (pop[g])  rp <= rp + 1'b1;
        case ({push[g], pop[g]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign empty[g] = (cnt == '0);
    assign full[g]  = (cnt == CNT_MAX);
    assign wptr_flat[g*AW +: AW] = wp;
    assign rptr_flat[g*AW +: AW] = rp;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      push[g] |-> !full[g]);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
      pop[g] |-> !empty[g]);
  end
endmodule

// File: rtl/mqr_store.sv
module mqr_store #(
  parameter int DW    = 18,
  parameter int ADDRW = 6,
  localparam int WORDS = 2 ** ADDRW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ADDRW-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [ADDRW-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mqr_seq.sv
module mqr_seq
  import mqr_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEVW   = 3,
  parameter int DEV_ID = 2,
  localparam int QW    = $clog2(NQ),
  localparam int RAW   = QW + DEVW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rd_addr,
  input  logic            rd_addr_en,
  input  logic            rd_en,
  input  logic            flag_strobe,
  input  logic [NQ-1:0]   q_empty,
  output logic            pop_en,
  output logic [QW-1:0]   pop_q,
  output logic            dout_valid,
  output logic [QW-1:0]   rd_qsel,
  output logic [DEVW-1:0] flag_dev,
  output logic            flag_hit
);
  localparam logic [DEVW-1:0] ID_L = DEVW'(DEV_ID);

  phase_t      phase;
  logic [QW-1:0] old_q;
  logic        dev_match, take, forced, want;

  assign dev_match = (rd_addr[RAW-1:QW] == ID_L);
  assign take      = rd_addr_en & dev_match;

  always_comb begin
    pop_q  = (phase == PH_OLD) ? old_q : rd_qsel;
    forced = (phase != PH_IDLE);
    want   = forced | ~dout_valid | rd_en;
    pop_en = want & ~q_empty[pop_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      old_q      <= '0;
      rd_qsel    <= '0;
      dout_valid <= 1'b0;
      flag_dev   <= '0;
      flag_hit   <= 1'b0;
    end else begin
      if (pop_en)    dout_valid <= 1'b1;
      else if (want) dout_valid <= 1'b0;

      if (take) begin
        old_q   <= rd_qsel;
        rd_qsel <= rd_addr[QW-1:0];
        phase   <= PH_OLD;
      end else begin
        phase <= (phase == PH_OLD) ? PH_NEW : PH_IDLE;
      end

      if (flag_strobe) begin
        flag_dev <= rd_addr[RAW-1:QW];
        flag_hit <= dev_match;
      end
    end
  end

  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rd_qsel));
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_strobe |=> ($stable(flag_dev) && $stable(flag_hit)));
endmodule

// File: rtl/mqr_read_port.sv
module mqr_read_port #(
  parameter int NQ     = 4,
  parameter int DW     = 18,
  parameter int DEPTH  = 16,
  parameter int DEVW   = 3,
  parameter int DEV_ID = 2,
  localparam int QW    = $clog2(NQ),
  localparam int AW    = $clog2(DEPTH),
  localparam int RAW   = QW + DEVW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [QW-1:0]   wr_q,
  input  logic [DW-1:0]   wr_data,
  input  logic [RAW-1:0]  rd_addr,
  input  logic            rd_addr_en,
  input  logic            rd_en,
  input  logic            flag_strobe,
  output logic [DW-1:0]   dout,
  output logic            dout_valid,
  output logic [QW-1:0]   rd_qsel,
  output logic [NQ-1:0]   q_empty,
  output logic [NQ-1:0]   q_full,
  output logic [DEVW-1:0] flag_dev,
  output logic            flag_hit
);
  localparam int ADDRW = QW + AW;

  logic [NQ-1:0]    push_vec, pop_vec;
  logic [NQ*AW-1:0] wptr_flat, rptr_flat;
  logic             push_ok, pop_en;
  logic [QW-1:0]    pop_q;
  logic [ADDRW-1:0] waddr, raddr;

  assign push_ok  = wr_en & ~q_full[wr_q];
  assign push_vec = push_ok ? (NQ'(1) << wr_q) : '0;
  assign pop_vec  = pop_en ? (NQ'(1) << pop_q) : '0;
  assign waddr    = {wr_q, wptr_flat[wr_q*AW +: AW]};
  assign raddr    = {pop_q, rptr_flat[pop_q*AW +: AW]};

  mqr_ptrs #(.NQ(NQ), .DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .push      (push_vec),
    .pop       (pop_vec),
    .empty     (q_empty),
    .full      (q_full),
    .wptr_flat (wptr_flat),
    .rptr_flat (rptr_flat)
  );

  mqr_store #(.DW(DW), .ADDRW(ADDRW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (push_ok),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (pop_en),
    .raddr (raddr),
    .rdata (dout)
  );

  mqr_seq #(.NQ(NQ), .DEVW(DEVW), .DEV_ID(DEV_ID)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .rd_addr     (rd_addr),
    .rd_addr_en  (rd_addr_en),
    .rd_en       (rd_en),
    .flag_strobe (flag_strobe),
    .q_empty     (q_empty),
    .pop_en      (pop_en),
    .pop_q       (pop_q),
    .dout_valid  (dout_valid),
    .rd_qsel     (rd_qsel),
    .flag_dev    (flag_dev),
    .flag_hit    (flag_hit)
  );

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> !q_empty[pop_q]);
  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pop_en |=> $stable(dout));
endmodule

// File: tb/tb_mqr_read_port.sv
module tb_mqr_read_port;
  localparam int ID = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_q = '0;
  logic [17:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic        rd_addr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        flag_strobe = 1'b0;
  logic [17:0] dout;
  logic        dout_valid;
  logic [1:0]  rd_qsel;
  logic [3:0]  q_empty, q_full;
  logic [2:0]  flag_dev;
  logic        flag_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mqr_read_port #(.DEV_ID(ID)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_addr_en(rd_addr_en), .rd_en(rd_en),
    .flag_strobe(flag_strobe), .dout(dout), .dout_valid(dout_valid),
    .rd_qsel(rd_qsel), .q_empty(q_empty), .q_full(q_full),
    .flag_dev(flag_dev), .flag_hit(flag_hit)
  );

  function automatic logic [17:0] dw(int q, int i);
    return 18'((q << 8) | i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_sel;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 valid", 32'(dout_valid), 0);
    chk("R1 qsel", 32'(rd_qsel), 0);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 empty", 32'(q_empty), 32'hF);
    chk("R1 full", 32'(q_full), 0);
    chk("R1 flag_dev", 32'(flag_dev), 0);

    // R3: fall-through latency on the selected queue
    wr_en = 1'b1; wr_q = 2'd0; wr_data = dw(0, 0);
    tick();
    chk("R3 not yet valid", 32'(dout_valid), 0);
    wr_data = dw(0, 1);
    tick();
    chk("R3 head dout", 32'(dout), 32'(dw(0, 0)));
    chk("R3 head valid", 32'(dout_valid), 1);
    wr_data = dw(0, 2); tick();
    wr_data = dw(0, 3); tick();
    wr_en = 1'b0;
    chk("R4 hold without rd_en", 32'(dout), 32'(dw(0, 0)));

    // R4: consume and hold
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R4 next word", 32'(dout), 32'(dw(0, 1)));
    tick(); tick();
    chk("R4 hold", 32'(dout), 32'(dw(0, 1)));
    chk("R4 hold valid", 32'(dout_valid), 1);

    // R2 / R10: fill queue 1 with 17 pushes while queue 0 is selected
    wr_en = 1'b1; wr_q = 2'd1;
    for (int i = 0; i < 17; i++) begin
      wr_data = dw(1, i);
      tick();
      chk("R10 dout untouched", 32'(dout), 32'(dw(0, 1)));
    end
    wr_en = 1'b0;
    chk("R2 full flags", 32'(q_full), 32'h2);
    chk("R10 valid untouched", 32'(dout_valid), 1);

    // R5: wrong device id and missing enable
    rd_addr = {3'(ID + 1), 2'd1}; rd_addr_en = 1'b1; tick(); rd_addr_en = 1'b0;
    chk("R5 id mismatch", 32'(rd_qsel), 0);
    tick();
    chk("R5 no forced word", 32'(dout), 32'(dw(0, 1)));
    rd_addr = {3'(ID), 2'd1}; tick();
    chk("R5 enable low", 32'(rd_qsel), 0);

    // R6 / R7: switch to queue 1 with rd_en high on the selecting edge
    rd_addr_en = 1'b1; rd_en = 1'b1; tick();
    rd_addr_en = 1'b0; rd_en = 1'b0;
    chk("R7 qsel", 32'(rd_qsel), 1);
    chk("R7 read from old queue", 32'(dout), 32'(dw(0, 2)));
    tick();
    chk("R6 forced old word", 32'(dout), 32'(dw(0, 3)));
    chk("R6 forced old valid", 32'(dout_valid), 1);
    tick();
    chk("R6 new head", 32'(dout), 32'(dw(1, 0)));
    tick();
    chk("R4 hold new head", 32'(dout), 32'(dw(1, 0)));
    rd_en = 1'b1;
    for (int i = 1; i < 16; i++) begin
      tick();
      chk("R4 drain order", 32'(dout), 32'(dw(1, i)));
    end
    tick(); rd_en = 1'b0;
    chk("R2 no 17th word valid", 32'(dout_valid), 0);
    chk("R4 dout kept", 32'(dout), 32'(dw(1, 15)));
    chk("R2 all empty", 32'(q_empty), 32'hF);

    // R8: switch away from a queue that empties on the forced read
    wr_en = 1'b1; wr_q = 2'd2; wr_data = dw(2, 0); tick();
    wr_data = dw(2, 1); tick();
    wr_q = 2'd1; wr_data = dw(1, 32); tick();
    wr_en = 1'b0; tick();
    chk("R3 refill head", 32'(dout), 32'(dw(1, 32)));
    rd_addr = {3'(ID), 2'd2}; rd_addr_en = 1'b1; tick(); rd_addr_en = 1'b0;
    chk("R7 select edge hold", 32'(dout), 32'(dw(1, 32)));
    tick();
    chk("R8 empty forced dout", 32'(dout), 32'(dw(1, 32)));
    chk("R8 empty forced valid", 32'(dout_valid), 0);
    rd_en = 1'b1; tick();
    chk("R6 new head with rd_en", 32'(dout), 32'(dw(2, 0)));
    tick();
    chk("R4 q2 second", 32'(dout), 32'(dw(2, 1)));
    tick(); rd_en = 1'b0;
    chk("R4 q2 drained", 32'(dout_valid), 0);

    // R9: flag strobe sweep over all address values
    for (int d = 0; d < 8; d++) begin
      for (int lo = 0; lo < 4; lo++) begin
        rd_addr = {3'(d), 2'(lo)}; flag_strobe = 1'b1; tick();
        chk("R9 flag_dev", 32'(flag_dev), 32'(d));
        chk("R9 flag_hit", 32'(flag_hit), 32'(d == ID));
        chk("R9 qsel untouched", 32'(rd_qsel), 2);
      end
    end
    flag_strobe = 1'b0; rd_addr = 5'b00000; tick();
    chk("R9 hold dev", 32'(flag_dev), 7);
    chk("R9 hold hit", 32'(flag_hit), 32'(ID == 7));

    // R5 / R7: select sweep with rd_en toggling
    exp_sel = 2'd2;
    rd_addr_en = 1'b1;
    for (int d = 0; d < 8; d++) begin
      for (int lo = 0; lo < 4; lo++) begin
        rd_addr = {3'(d), 2'(lo)}; rd_en = lo[0]; tick();
        if (d == ID) exp_sel = 2'(lo);
        chk("R5 select sweep", 32'(rd_qsel), 32'(exp_sel));
      end
    end
    rd_addr_en = 1'b0; rd_en = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule